// File: doc/BRIEF.md
# Timer Interrupt Routing Controller

This block sits between a bank of timer channels and the interrupt fabric. Each timer raises a one-cycle expiry pulse. The block delivers that pulse to one of three targets. The first is a message carrying an 8-bit vector and an 8-bit destination. The second is one line of a 32-line interrupt pin bus. The third is nothing, when the timer is unrouted or disabled. Each timer has its own configuration and message registers, written through a shared write port. Timers using level signalling keep a status bit, and the pin stays asserted until software clears that bit or the configuration stops matching it.

A global legacy switch takes over timers 0 and 1. While it is on, they drive fixed pins as edge interrupts, whatever their message settings. The block rejects pin routes outside a build-time allowed mask. It also drops a held level as soon as the timer is disabled, switched to edge or message signalling, or moved to another pin. This keeps a pin from being stuck high by a stale configuration. When several timers share a pin, their requests are merged. Message requests that arrive in the same cycle are queued and sent one per cycle.

Top module: `tir_router`

## Requirements
- R1: After reset, `pin_out`, `stat_o` and `msg_valid` are all zero and every timer is disabled, so an expiry produces no output.
- R2: With configuration bit 1 clear (edge), bit 2 set (enable) and a non-zero route in bits 13:9, an expiry sampled at edge k drives the routed pin high for exactly the one cycle after edge k+1 and sets no status bit.
- R3: With bit 1 set (level), an expiry sampled at edge k sets `stat_o[i]` at edge k. The routed pin rises at edge k+1 and stays high while the status bit stays set.
- R4: An expiry has no effect (no pin change, no message) when the timer's enable bit 2 is clear or its status bit is already set.
- R5: A timer uses message delivery only if its `MSG_CAP` bit and configuration bit 14 are both set. An expiry then gives one `msg_valid` cycle after edge k+1, with `msg_vector` equal to message-register bits 7:0 and `msg_dest` equal to bits 51:44, and no pin activity. Without capability, the pin route is used.
- R6: While `legacy_en` is high, timer 0 drives pin 2 and timer 1 drives pin 8, always as edge pulses, ignoring bit 14, bit 1 and the route field.
- R7: On a configuration write, a non-zero effective pin whose bit is clear in `ALLOWED_PINS` forces the stored route to 0. Route 0 means unconnected, and an expiry then drives nothing.
- R8: A set status bit is cleared within two edges of the write that disables the timer, selects edge or message delivery, or changes its pin. The old pin drops one edge later.
- R9: Writing a 1 to `stat_clr[i]` clears a set status bit at the edge that samples it, and the pin drops one edge later.
- R10: A pin is the OR of all level holds and pulses routed to it, and stays high until its last holder releases it.
- R11: Message requests are sent lowest timer index first, one per cycle. A repeat expiry of a timer whose message is still queued adds no second message. `msg_bcast` is high when `msg_dest` is 8'hFF.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_en | input | 1 | Global legacy override for timers 0 and 1 |
| cfg_we | input | 1 | Write `wr_data` to the configuration of timer `wr_idx` |
| msg_we | input | 1 | Write `wr_data` to the message register of timer `wr_idx` |
| wr_idx | input | $clog2(NUM_TIMERS) | Timer selected for a write |
| wr_data | input | 64 | Write data |
| stat_clr | input | NUM_TIMERS | Write-one-to-clear for the status bits |
| expire | input | NUM_TIMERS | One-cycle expiry pulse per timer |
| pin_out | output | 32 | Interrupt pin bus, registered |
| stat_o | output | NUM_TIMERS | Level status bits |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination ID |
| msg_bcast | output | 1 | Destination is the broadcast value |

## Verification
A corrupted route or mode decode shows at the pins on the second edge after the expiry. It appears as a pulse on the wrong line, a level where a pulse belongs, or a missing message. A stale status bit appears as a pin that stays high, or as a later expiry that is silently dropped. The bench therefore checks the bus and the status bits for three cycles after every expiry, and again three cycles after each reconfiguration. A faulty message queue shows as a wrong vector order or a doubled strobe in the cycles right after a multi-timer expiry.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int PINS  = 32;
  localparam int PIN_W = 5;

  // configuration bit positions (stored subset)
  localparam int CB_LEVEL  = 1;
  localparam int CB_IE     = 2;
  localparam int CB_ROUTE  = 9;
  localparam int CB_MSG_EN = 14;
  // message register fields
  localparam int MB_VEC  = 0;
  localparam int MB_DEST = 44;

  typedef struct packed {
    logic             msg_en;
    logic [PIN_W-1:0] route;
    logic             ie;
    logic             level;
  } cfg_t;

  typedef struct packed {
    logic             use_msg;
    logic             edge_trig;
    logic [PIN_W-1:0] pin;
  } route_t;

  // Effective delivery for a timer: legacy override first, then message, then pin route.
  function automatic route_t tir_decode(cfg_t c, logic leg, logic [PIN_W-1:0] leg_pin, logic cap);
    route_t r;
    r.use_msg   = !leg && cap && c.msg_en;
    r.edge_trig = leg ? 1'b1 : !c.level;
    if (r.use_msg)  r.pin = '0;
    else if (leg)   r.pin = leg_pin;
    else            r.pin = c.route;
    return r;
  endfunction
endpackage

// File: rtl/tir_timer_chan.sv
module tir_timer_chan
  import tir_pkg::*;
#(
  parameter int          IDX     = 0,
  parameter logic        CAP     = 1'b1,
  parameter logic [31:0] ALLOWED = 32'hFFFF_FFFE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legacy_i,
  input  logic             cfg_we_i,
  input  cfg_t             cfg_wr_i,
  input  logic             msg_we_i,
  input  logic [7:0]       vec_wr_i,
  input  logic [7:0]       dest_wr_i,
  input  logic             clr_i,
  input  logic             expire_i,
  output logic             status_o,
  output logic [PIN_W-1:0] lvl_pin_o,
  output logic             pulse_o,
  output logic [PIN_W-1:0] pulse_pin_o,
  output logic             msg_req_o,
  output logic [7:0]       vec_o,
  output logic [7:0]       dest_o
);
  localparam logic             LEG_SLOT = (IDX < 2);
  localparam logic [PIN_W-1:0] LEG_PIN  = (IDX == 0) ? PIN_W'(2) : PIN_W'(8);

  cfg_t             cfg_q;
  logic             status_q, pulse_q;
  logic [PIN_W-1:0] lvl_pin_q, pulse_pin_q;
  logic [7:0]       vec_q, dest_q;

  logic   leg;
  route_t cur, wr;
  cfg_t   cfg_fixed;
  logic   stale, fire, fire_pin;

  always_comb begin
    leg   = legacy_i & LEG_SLOT;
    cur   = tir_decode(cfg_q, leg, LEG_PIN, CAP);
    wr    = tir_decode(cfg_wr_i, leg, LEG_PIN, CAP);
    cfg_fixed = cfg_wr_i;
    if (wr.pin != '0 && !ALLOWED[wr.pin]) cfg_fixed.route = '0;
    stale    = status_q && (!cfg_q.ie || cur.use_msg || cur.edge_trig || cur.pin != lvl_pin_q);
    fire     = expire_i && cfg_q.ie && !status_q;
    fire_pin = fire && !cur.use_msg && (cur.pin != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      status_q    <= 1'b0;
      lvl_pin_q   <= '0;
      pulse_q     <= 1'b0;
      pulse_pin_q <= '0;
      vec_q       <= '0;
      dest_q      <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_fixed;
      if (msg_we_i) begin
        vec_q  <= vec_wr_i;
        dest_q <= dest_wr_i;
      end
      if (stale || clr_i) begin
        status_q <= 1'b0;
      end else if (fire_pin && !cur.edge_trig) begin
        status_q  <= 1'b1;
        lvl_pin_q <= cur.pin;
      end
      pulse_q <= fire_pin && cur.edge_trig;
      if (fire_pin && cur.edge_trig) pulse_pin_q <= cur.pin;
    end
  end

  assign status_o    = status_q;
  assign lvl_pin_o   = lvl_pin_q;
  assign pulse_o     = pulse_q;
  assign pulse_pin_o = pulse_pin_q;
  assign msg_req_o   = fire && cur.use_msg;
  assign vec_o       = vec_q;
  assign dest_o      = dest_q;

  a_r8_stale_release: assert property (@(posedge clk) disable iff (rst)
    (status_q && !cfg_q.ie) |=> !status_q);
  a_r4_no_refire: assert property (@(posedge clk) disable iff (rst)
    (expire_i && status_q) |=> !pulse_q);
  a_r3_level_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(expire_i));
  a_r6_legacy_pin: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && $past(legacy_i) && LEG_SLOT) |-> (pulse_pin_q == LEG_PIN));
endmodule

// File: rtl/tir_msg_arb.sv
module tir_msg_arb #(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [N-1:0] req_i,
  input  logic [7:0] vec_i  [N],
  input  logic [7:0] dest_i [N],
  output logic       valid_o,
  output logic [7:0] vec_o,
  output logic [7:0] dest_o,
  output logic       bcast_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     pend_q, gnt_mask;
  logic [IDX_W-1:0] gnt_idx;
  logic             any;

  always_comb begin
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) gnt_idx = IDX_W'(i);
    end
    any      = |pend_q;
    gnt_mask = any ? (N'(1) << gnt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      valid_o <= 1'b0;
      vec_o   <= '0;
      dest_o  <= '0;
      bcast_o <= 1'b0;
    end else begin
      pend_q  <= (pend_q & ~gnt_mask) | req_i;
      valid_o <= any;
      if (any) begin
        vec_o   <= vec_i[gnt_idx];
        dest_o  <= dest_i[gnt_idx];
        bcast_o <= (dest_i[gnt_idx] == 8'hFF);
      end
    end
  end

  a_r11_from_queue: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(|pend_q));
  a_r11_drain: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |=> valid_o);
endmodule

// File: rtl/tir_pin_merge.sv
module tir_pin_merge
  import tir_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     lvl_v_i,
  input  logic [PIN_W-1:0] lvl_pin_i [N],
  input  logic [N-1:0]     pls_v_i,
  input  logic [PIN_W-1:0] pls_pin_i [N],
  output logic [PINS-1:0]  pins_o
);
  logic [PINS-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (lvl_v_i[i]) acc[lvl_pin_i[i]] = 1'b1;
      if (pls_v_i[i]) acc[pls_pin_i[i]] = 1'b1;
    end
    acc[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pins_o <= '0;
    else     pins_o <= acc;
  end

  a_r10_level_live: assert property (@(posedge clk) disable iff (rst)
    (|lvl_v_i) |=> (pins_o != '0));
  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    (!(|lvl_v_i) && !(|pls_v_i)) |=> (pins_o == '0));
endmodule

// File: rtl/tir_router.sv
module tir_router
  import tir_pkg::*;
#(
  parameter int                  NUM_TIMERS   = 8,
  parameter logic [NUM_TIMERS-1:0] MSG_CAP    = '1,
  parameter logic [31:0]         ALLOWED_PINS = 32'h0000_FFFE,
  localparam int                 IDX_W        = $clog2(NUM_TIMERS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  legacy_en,
  input  logic                  cfg_we,
  input  logic                  msg_we,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [63:0]           wr_data,
  input  logic [NUM_TIMERS-1:0] stat_clr,
  input  logic [NUM_TIMERS-1:0] expire,
  output logic [31:0]           pin_out,
  output logic [NUM_TIMERS-1:0] stat_o,
  output logic                  msg_valid,
  output logic [7:0]            msg_vector,
  output logic [7:0]            msg_dest,
  output logic                  msg_bcast
);
  cfg_t       cfg_wr;
  logic [7:0] vec_wr, dest_wr;
  logic       unused_wr;

  always_comb begin
    cfg_wr.level  = wr_data[CB_LEVEL];
    cfg_wr.ie     = wr_data[CB_IE];
    cfg_wr.route  = wr_data[CB_ROUTE +: PIN_W];
    cfg_wr.msg_en = wr_data[CB_MSG_EN];
    vec_wr        = wr_data[MB_VEC +: 8];
    dest_wr       = wr_data[MB_DEST +: 8];
  end
  assign unused_wr = ^{wr_data[63:52], wr_data[43:15], wr_data[8]};

  logic [NUM_TIMERS-1:0] pulse_v, msg_req;
  logic [PIN_W-1:0]      lvl_pin [NUM_TIMERS];
  logic [PIN_W-1:0]      pls_pin [NUM_TIMERS];
  logic [7:0]            vec_a   [NUM_TIMERS];
  logic [7:0]            dest_a  [NUM_TIMERS];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
    tir_timer_chan #(
      .IDX     (g),
      .CAP     (MSG_CAP[g]),
      .ALLOWED (ALLOWED_PINS)
    ) chan_i (
      .clk         (clk),
      .rst         (rst),
      .legacy_i    (legacy_en),
      .cfg_we_i    (cfg_we && (wr_idx == IDX_W'(g))),
      .cfg_wr_i    (cfg_wr),
      .msg_we_i    (msg_we && (wr_idx == IDX_W'(g))),
      .vec_wr_i    (vec_wr),
      .dest_wr_i   (dest_wr),
      .clr_i       (stat_clr[g]),
      .expire_i    (expire[g]),
      .status_o    (stat_o[g]),
      .lvl_pin_o   (lvl_pin[g]),
      .pulse_o     (pulse_v[g]),
      .pulse_pin_o (pls_pin[g]),
      .msg_req_o   (msg_req[g]),
      .vec_o       (vec_a[g]),
      .dest_o      (dest_a[g])
    );
  end

  tir_pin_merge #(.N(NUM_TIMERS)) merge_i (
    .clk       (clk),
    .rst       (rst),
    .lvl_v_i   (stat_o),
    .lvl_pin_i (lvl_pin),
    .pls_v_i   (pulse_v),
    .pls_pin_i (pls_pin),
    .pins_o    (pin_out)
  );

  tir_msg_arb #(.N(NUM_TIMERS)) arb_i (
    .clk     (clk),
    .rst     (rst),
    .req_i   (msg_req),
    .vec_i   (vec_a),
    .dest_i  (dest_a),
    .valid_o (msg_valid),
    .vec_o   (msg_vector),
    .dest_o  (msg_dest),
    .bcast_o (msg_bcast)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (stat_o == '0 && !msg_valid));
endmodule

// File: tb/tir_router_tb_top.sv
module tir_router_tb_top;
  localparam int N = 8;

  logic        clk = 0, rst = 1, legacy_en = 0, cfg_we = 0, msg_we = 0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [N-1:0] stat_clr = '0, expire = '0;
  logic [31:0] pin_out;
  logic [N-1:0] stat_o;
  logic        msg_valid, msg_bcast;
  logic [7:0]  msg_vector, msg_dest;

  always #2 clk = ~clk;

  tir_router #(.NUM_TIMERS(N), .MSG_CAP(8'hBF), .ALLOWED_PINS(32'h0000_FFFE)) dut_i (
    .clk(clk), .rst(rst), .legacy_en(legacy_en), .cfg_we(cfg_we), .msg_we(msg_we),
    .wr_idx(wr_idx), .wr_data(wr_data), .stat_clr(stat_clr), .expire(expire),
    .pin_out(pin_out), .stat_o(stat_o), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_bcast(msg_bcast));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wcfg(input int idx, input logic [63:0] d);
    wr_idx = 3'(idx); wr_data = d; cfg_we = 1; tick(); cfg_we = 0;
  endtask
  task automatic wmsg(input int idx, input logic [7:0] vec, input logic [7:0] dst);
    wr_idx = 3'(idx); wr_data = (64'(dst) << 44) | 64'(vec); msg_we = 1; tick(); msg_we = 0;
  endtask
  task automatic fire(input logic [N-1:0] m);
    expire = m; tick(); expire = '0;
  endtask

  // {idx[3], legacy[1], cfg[16], kind[2], pin[5]}; kind 0 none, 1 pulse, 2 level, 3 message
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {3'd3, 1'b0, 16'h0A04, 2'd1, 5'd5},   // R2 edge pin 5
    {3'd4, 1'b0, 16'h0E06, 2'd2, 5'd7},   // R3 level pin 7
    {3'd2, 1'b0, 16'h0A00, 2'd0, 5'd0},   // R4 disabled
    {3'd5, 1'b0, 16'h4004, 2'd3, 5'd0},   // R5 message
    {3'd0, 1'b1, 16'h4606, 2'd1, 5'd2},   // R6 legacy timer 0
    {3'd1, 1'b1, 16'h0004, 2'd1, 5'd8},   // R6 legacy timer 1
    {3'd2, 1'b0, 16'h2806, 2'd0, 5'd0},   // R7 route 20 rejected
    {3'd7, 1'b0, 16'h0006, 2'd0, 5'd0},   // R7 route 0
    {3'd6, 1'b0, 16'h5206, 2'd2, 5'd9},   // R5 incapable -> pin 9
    {3'd0, 1'b0, 16'h0806, 2'd2, 5'd4},   // R3 level pin 4, legacy off
    {3'd3, 1'b0, 16'h1E04, 2'd1, 5'd15}   // R7 highest allowed pin
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    // R1 reset state
    chk(pin_out == 0 && stat_o == 0 && !msg_valid, "R1 reset outputs", {pin_out, 24'd0, stat_o}, 0);
    fire('1); tick(); tick();
    chk(pin_out == 0 && stat_o == 0 && !msg_valid, "R1 disabled after reset", {pin_out, 24'd0, stat_o}, 0);

    wmsg(5, 8'h41, 8'h23);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] idx; logic leg; logic [15:0] cf; logic [1:0] kind; logic [4:0] pin;
      logic [31:0] pm; bit ok;
      {idx, leg, cf, kind, pin} = VEC[v];
      pm = (kind == 2'd1 || kind == 2'd2) ? (32'd1 << pin) : 32'd0;
      ok = 1;
      legacy_en = leg;
      wcfg(idx, 64'(cf));
      fire(8'(1) << idx);
      for (int c = 1; c <= 3; c++) begin
        logic [31:0] ep; logic es, ev;
        ep = (kind == 2'd2 && c >= 2) ? pm : (kind == 2'd1 && c == 2) ? pm : 32'd0;
        es = (kind == 2'd2);
        ev = (kind == 2'd3 && c == 2);
        if (pin_out != ep || stat_o[idx] != es || msg_valid != ev) ok = 0;
        if (ev && (msg_vector != 8'h41 || msg_dest != 8'h23 || msg_bcast)) ok = 0;
        if (c < 3) tick();
      end
      chk(ok, $sformatf("R2/R3/R4/R5/R6/R7 vector %0d", v), {pin_out, 24'd0, stat_o}, {pm, 32'd0});
      wcfg(idx, 64'd0);
      legacy_en = 0;
      tick(); tick();
      chk(pin_out == 0 && stat_o == 0 && !msg_valid, $sformatf("R8 disable release vector %0d", v),
          {pin_out, 24'd0, stat_o}, 0);
    end

    // R4 repeat expiry while status set
    wcfg(4, 64'h0E06); fire(8'h10); tick();
    fire(8'h10); tick();
    chk(pin_out == 32'h80 && stat_o == 8'h10 && !msg_valid, "R4 refire ignored", {pin_out, 24'd0, stat_o}, {32'h80, 32'h10});
    // R9 write-one-to-clear
    stat_clr = 8'h10; tick(); stat_clr = 0;
    chk(stat_o == 0, "R9 status cleared", 64'(stat_o), 0);
    tick();
    chk(pin_out == 0, "R9 pin dropped", 64'(pin_out), 0);
    // R8 reroute
    fire(8'h10); tick();
    wcfg(4, 64'h1206); tick(); tick();
    chk(pin_out == 0 && stat_o == 0, "R8 reroute release", {pin_out, 24'd0, stat_o}, 0);
    // R8 level -> edge
    fire(8'h10); tick();
    chk(stat_o == 8'h10 && pin_out == 32'h200, "R3 level pin 9", {pin_out, 24'd0, stat_o}, {32'h200, 32'h10});
    wcfg(4, 64'h1204); tick(); tick();
    chk(pin_out == 0 && stat_o == 0, "R8 edge release", {pin_out, 24'd0, stat_o}, 0);
    // R8 level -> message
    wcfg(5, 64'h0606); fire(8'h20); tick();
    wcfg(5, 64'h4606); tick(); tick();
    chk(pin_out == 0 && stat_o == 0 && !msg_valid, "R8 message release", {pin_out, 24'd0, stat_o}, 0);

    // R10 shared pin
    wcfg(2, 64'h0C06); wcfg(3, 64'h0C06);
    fire(8'h0C); tick();
    stat_clr = 8'h04; tick(); stat_clr = 0; tick();
    chk(pin_out == 32'h40 && stat_o == 8'h08, "R10 pin held by second timer", {pin_out, 24'd0, stat_o}, {32'h40, 32'h08});
    stat_clr = 8'h08; tick(); stat_clr = 0; tick();
    chk(pin_out == 0, "R10 pin released by last holder", 64'(pin_out), 0);
    wcfg(2, 0); wcfg(3, 0);

    // R11 ordering, merge and broadcast
    wmsg(7, 8'h77, 8'hFF);
    wcfg(7, 64'h4004);
    fire(8'hA0);
    fire(8'h80);
    chk(msg_valid && msg_vector == 8'h41 && msg_dest == 8'h23 && !msg_bcast, "R11 first lowest index",
        {48'd0, msg_vector, msg_dest}, {48'd0, 16'h4123});
    tick();
    chk(msg_valid && msg_vector == 8'h77 && msg_bcast, "R11 second broadcast", {55'd0, msg_bcast, msg_vector}, {55'd1, 8'h77});
    tick();
    chk(!msg_valid && pin_out == 0, "R11 merged repeat no extra message", 64'(msg_valid), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule